// File: doc/BRIEF.md
# NAND Block Programming Sequencer

This control block writes an image into a NAND array one erase block at a time. A single request port reaches the flash, and the pin timing and ECC arithmetic sit behind that port. Software, or a larger controller, gives the sequencer three things: a start pulse, the first physical block to use and the image length in blocks. The sequencer then places image block 0, 1, 2 and so on in turn into successive physical blocks. It passes over any block whose factory marker says it is unusable.

Each candidate block goes through the same steps. The sequencer reads the marker byte from page 0 and from page 1. If both are good, it erases the block, programs every page in ascending order, and reads every page back so the ECC unit can compare it. If the erase fails, a program fails, or the read-back finds an uncorrectable error, the sequencer writes a bad marker into that block and places the same image block again in the next physical block. When all image blocks are placed, the run ends with `done`. If the sequencer runs past the last block of the device first, the run ends with `error`. The port answers each request with one acknowledge cycle. That cycle carries a fail flag and, for marker reads, the marker byte. The port also holds the acknowledge back while the device is busy, so the long erase and program times are absorbed there.

Top module: `nand_burn_seq`

## Requirements
- R1: After reset the sequencer is idle: `busy`, `done`, `error` and `op_req` are low and `skip_cnt` is zero.
- R2: A block is examined by a marker read (op code 0) of page 0 and then page 1. `op_rdata` returns the marker byte. The block is usable only when both bytes equal 0xFF. When page 0 is not good, page 1 is not read.
- R3: A block with a bad marker is never erased. `skip_cnt` increments, and the next physical block is examined for the same image block.
- R4: A usable block receives one erase (op code 1), then program requests (op code 2) for pages 0 to PAGES-1 in ascending order, then read-back requests (op code 3) for pages 0 to PAGES-1 in ascending order. Each request carries the block on `op_blk`, the page on `op_page` and the current image block index on `op_img`.
- R5: When `op_fail` is high on the acknowledge of an erase, program or read-back request, the sequencer issues no further request of that kind to the block. It issues one mark-bad request (op code 4, page 0) to that block, increments `skip_cnt`, and retries the same image index on the next physical block.
- R6: At most one request is outstanding. `op_req` stays high with `op_code`, `op_blk`, `op_page` and `op_img` unchanged until `op_ack`, and it is low in the cycle after an acknowledge.
- R7: When all image blocks are placed, `done` rises. When a block other than the last is needed after the device's last block (NBLK-1), `error` rises instead. Both flags are held until the next start, and they are never high together. `busy` is high only while a run is in progress.
- R8: A start with an image length of zero ends in `done` with no flash request.
- R9: A block marked bad by the sequencer reads back as bad in a later run and is skipped without an erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a run when the sequencer is not busy |
| img_len | input | BW+1 | Number of image blocks to place |
| first_blk | input | BW | First physical block to try |
| op_req | output | 1 | Request valid |
| op_code | output | 3 | 0 read marker, 1 erase, 2 program page, 3 read-back page, 4 mark bad |
| op_blk | output | BW | Physical block of the request |
| op_page | output | PW | Page of the request |
| op_img | output | BW+1 | Image block index being placed |
| op_ack | input | 1 | One-cycle acknowledge of the request |
| op_fail | input | 1 | With `op_ack`: device failure or uncorrectable ECC |
| op_rdata | input | 8 | With `op_ack` on a marker read: the marker byte |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Run finished with all blocks placed |
| error | output | 1 | Run stopped at the end of the device |
| skip_cnt | output | BW+1 | Blocks passed over in this run, factory-bad or newly marked |

## Verification
A wrong state or page counter shows up at the request port. The bench compares every request against a queue built from the requirements, so a misplaced step appears as a wrong op code, block or page on the very next request. A lost retry or a miscounted skip shows up as a wrong `op_img` on the following block, and as a wrong `skip_cnt` or final flag within a cycle of the run's end. A protocol slip, such as a field changing under a pending request or a second request, is caught on the clock where it happens.

// File: rtl/nand_burn_seq.sv
module nand_burn_seq #(
  parameter int NBLK = 4096,
  parameter int PAGES = 32,
  parameter logic [7:0] GOOD_MARK = 8'hFF,
  localparam int BW = $clog2(NBLK),
  localparam int PW = $clog2(PAGES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [BW:0]   img_len,
  input  logic [BW-1:0] first_blk,
  output logic          op_req,
  output logic [2:0]    op_code,
  output logic [BW-1:0] op_blk,
  output logic [PW-1:0] op_page,
  output logic [BW:0]   op_img,
  input  logic          op_ack,
  input  logic          op_fail,
  input  logic [7:0]    op_rdata,
  output logic          busy,
  output logic          done,
  output logic          error,
  output logic [BW:0]   skip_cnt
);
  typedef enum logic [3:0] {
    S_IDLE, S_CHECK, S_ERASE, S_PROG, S_VERIFY, S_MARK, S_NEXT, S_DONE, S_FAIL
  } st_t;

  st_t st;
  logic pend;
  logic [BW-1:0] phys;
  logic [PW-1:0] page;
  logic [BW:0] img, len_r, skips;

  wire req_state = (st == S_CHECK) || (st == S_ERASE) || (st == S_PROG) ||
                   (st == S_VERIFY) || (st == S_MARK);
  wire acked   = pend && op_ack;
  wire last_pg = (page == PW'(PAGES - 1));

  assign op_req   = pend;
  assign op_blk   = phys;
  assign op_page  = page;
  assign op_img   = img;
  assign skip_cnt = skips;
  assign done     = (st == S_DONE);
  assign error    = (st == S_FAIL);
  assign busy     = !(st == S_IDLE || st == S_DONE || st == S_FAIL);

  always_comb begin
    case (st)
      S_ERASE:  op_code = 3'd1;
      S_PROG:   op_code = 3'd2;
      S_VERIFY: op_code = 3'd3;
      S_MARK:   op_code = 3'd4;
      default:  op_code = 3'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      pend <= 1'b0;
      phys <= '0;
      page <= '0;
      img <= '0;
      len_r <= '0;
      skips <= '0;
    end else begin
      if (acked) pend <= 1'b0;
      else if (req_state && !pend) pend <= 1'b1;

      case (st)
        S_IDLE, S_DONE, S_FAIL: if (start) begin
          phys  <= first_blk;
          img   <= '0;
          len_r <= img_len;
          skips <= '0;
          page  <= '0;
          if (img_len == '0) st <= S_DONE;
          else if ({1'b0, first_blk} >= (BW+1)'(NBLK)) st <= S_FAIL;
          else st <= S_CHECK;
        end
        S_CHECK: if (acked) begin
          if (op_rdata != GOOD_MARK) begin
            skips <= skips + 1'b1;
            st <= S_NEXT;
          end else if (page != '0) begin
            page <= '0;
            st <= S_ERASE;
          end else page <= PW'(1);
        end
        S_ERASE: if (acked) st <= op_fail ? S_MARK : S_PROG;
        S_PROG: if (acked) begin
          if (op_fail) begin page <= '0; st <= S_MARK; end
          else if (last_pg) begin page <= '0; st <= S_VERIFY; end
          else page <= page + 1'b1;
        end
        S_VERIFY: if (acked) begin
          if (op_fail) begin page <= '0; st <= S_MARK; end
          else if (last_pg) begin page <= '0; img <= img + 1'b1; st <= S_NEXT; end
          else page <= page + 1'b1;
        end
        S_MARK: if (acked) begin
          skips <= skips + 1'b1;
          st <= S_NEXT;
        end
        S_NEXT: begin
          page <= '0;
          if (img == len_r) st <= S_DONE;
          else if (phys == BW'(NBLK - 1)) st <= S_FAIL;
          else begin phys <= phys + 1'b1; st <= S_CHECK; end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module nand_burn_seq_chk #(parameter int BW = 12, parameter int PW = 5) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_req,
  input logic [2:0]    op_code,
  input logic [BW-1:0] op_blk,
  input logic [PW-1:0] op_page,
  input logic [BW:0]   op_img,
  input logic          op_ack,
  input logic          busy,
  input logic          done,
  input logic          error,
  input logic [BW:0]   skip_cnt
);
  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_req && !op_ack |=> op_req && $stable(op_code) && $stable(op_blk) &&
                          $stable(op_page) && $stable(op_img));
  // R6
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_req && op_ack |=> !op_req);
  // R7
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error) && !(busy && (done || error)));
  // R7
  req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_req |-> busy);
  // R3
  skip_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> skip_cnt >= $past(skip_cnt));
  // R4
  op_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_req |-> op_code <= 3'd4);
endmodule

bind nand_burn_seq nand_burn_seq_chk #(.BW(BW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_req(op_req), .op_code(op_code), .op_blk(op_blk),
  .op_page(op_page), .op_img(op_img), .op_ack(op_ack), .busy(busy), .done(done),
  .error(error), .skip_cnt(skip_cnt));

// File: tb/sim_nand_burn_seq.sv
`timescale 1ns/1ps
module sim_nand_burn_seq;
  localparam int NBLK = 16;
  localparam int PAGES = 32;
  localparam int BW = 4;
  localparam int PW = 5;

  logic clk = 0, rst_n = 0, start = 0;
  logic [BW:0] img_len = '0;
  logic [BW-1:0] first_blk = '0;
  logic op_req, busy, done, error;
  logic [2:0] op_code;
  logic [BW-1:0] op_blk;
  logic [PW-1:0] op_page;
  logic [BW:0] op_img, skip_cnt;
  logic op_ack = 0, op_fail = 0;
  logic [7:0] op_rdata = 8'h00;

  always #4 clk = ~clk;

  nand_burn_seq #(.NBLK(NBLK), .PAGES(PAGES)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .img_len(img_len), .first_blk(first_blk),
    .op_req(op_req), .op_code(op_code), .op_blk(op_blk), .op_page(op_page), .op_img(op_img),
    .op_ack(op_ack), .op_fail(op_fail), .op_rdata(op_rdata),
    .busy(busy), .done(done), .error(error), .skip_cnt(skip_cnt));

  int tests = 0, fails = 0;
  logic [7:0] mk0 [NBLK], mk1 [NBLK];
  bit efail [NBLK];
  int pfail [NBLK], vfail [NBLK];
  int q_code[$], q_blk[$], q_page[$], q_img[$];
  int exp_skip; bit exp_err;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push(int c, int b, int p, int i);
    q_code.push_back(c); q_blk.push_back(b); q_page.push_back(p); q_img.push_back(i);
  endtask

  // Expected request stream built from R2-R5, R7, R8
  task automatic plan(int first, int len);
    int b = first, img = 0;
    bit bad;
    exp_skip = 0; exp_err = 0;
    if (len == 0) return;
    forever begin
      push(0, b, 0, img);
      if (mk0[b] != 8'hFF) exp_skip++;
      else begin
        push(0, b, 1, img);
        if (mk1[b] != 8'hFF) exp_skip++;
        else begin
          push(1, b, 0, img);
          bad = efail[b];
          if (!bad) for (int p = 0; p < PAGES; p++) begin
            push(2, b, p, img);
            if (pfail[b] == p) begin bad = 1; break; end
          end
          if (!bad) for (int p = 0; p < PAGES; p++) begin
            push(3, b, p, img);
            if (vfail[b] == p) begin bad = 1; break; end
          end
          if (bad) begin push(4, b, 0, img); exp_skip++; end
          else img++;
        end
      end
      if (img == len) break;
      if (b == NBLK - 1) begin exp_err = 1; break; end
      b++;
    end
  endtask

  // Flash port model, responding on falling edges
  initial begin
    int lat = -1;
    logic [7:0] rd = 0;
    bit fl = 0;
    forever begin
      @(negedge clk);
      if (op_ack) begin op_ack = 0; op_fail = 0; end
      else if (op_req) begin
        if (lat < 0) begin
          if (q_code.size() == 0) chk(0, "R6", "unexpected request code", op_code, -1);
          else begin
            chk(op_code == 3'(q_code[0]), "R4", "op_code", op_code, q_code[0]);
            chk(op_blk == BW'(q_blk[0]), "R3", "op_blk", op_blk, q_blk[0]);
            chk(op_page == PW'(q_page[0]), "R2", "op_page", op_page, q_page[0]);
            chk(op_img == (BW+1)'(q_img[0]), "R5", "op_img", op_img, q_img[0]);
            void'(q_code.pop_front()); void'(q_blk.pop_front());
            void'(q_page.pop_front()); void'(q_img.pop_front());
          end
          rd = 8'h00; fl = 0;
          case (op_code)
            3'd0: rd = (op_page == 0) ? mk0[op_blk] : mk1[op_blk];
            3'd1: fl = efail[op_blk];
            3'd2: fl = (pfail[op_blk] == int'(op_page));
            3'd3: fl = (vfail[op_blk] == int'(op_page));
            3'd4: mk0[op_blk] = 8'h00;
            default: ;
          endcase
          lat = (op_code == 3'd1) ? 6 : (op_code == 3'd2) ? 3 : 1;
        end
        lat--;
        if (lat == 0) begin op_ack = 1; op_fail = fl; op_rdata = rd; lat = -1; end
      end
    end
  end

  task automatic run(int first, int len, string req);
    int wd = 0;
    plan(first, len);
    @(negedge clk);
    first_blk = BW'(first); img_len = (BW+1)'(len); start = 1;
    @(negedge clk); start = 0;
    @(negedge clk);
    while (busy && wd < 20000) begin @(negedge clk); wd++; end
    chk(wd < 20000, "R7", "watchdog", wd, 0);
    chk(done == !exp_err, req, "done", done, !exp_err);
    chk(error == exp_err, req, "error", error, exp_err);
    chk(skip_cnt == (BW+1)'(exp_skip), "R3", "skip_cnt", skip_cnt, exp_skip);
    chk(q_code.size() == 0, "R4", "requests left", q_code.size(), 0);
    q_code.delete(); q_blk.delete(); q_page.delete(); q_img.delete();
  endtask

  initial begin
    for (int b = 0; b < NBLK; b++) begin
      mk0[b] = 8'hFF; mk1[b] = 8'hFF; efail[b] = 0; pfail[b] = -1; vfail[b] = -1;
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !error && !op_req, "R1", "flags idle", {busy, done, error, op_req}, 0);
    chk(skip_cnt == 0, "R1", "skip_cnt", skip_cnt, 0);
    rst_n = 1;
    @(negedge clk);
    // R4 clean two blocks
    run(0, 2, "R4");
    // R2 page-0 and page-1 markers bad
    mk0[3] = 8'h00; mk1[4] = 8'hF0;
    run(2, 2, "R2");
    // R5 erase fail, program fail mid-block, read-back fail on last page
    efail[6] = 1; pfail[7] = 10; vfail[8] = PAGES - 1;
    run(6, 1, "R5");
    // R9 newly marked blocks are now skipped
    run(6, 1, "R9");
    // R7 end of device reached
    run(14, 3, "R7");
    // R8 zero length
    run(5, 0, "R8");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1500000;
    fails++; tests++;
    $display("FAIL R7 global watchdog: actual %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule